// File: doc/BRIEF.md
# Sandcastle Measurement-Line Sequencer

This block turns the level-decoded parts of a sandcastle timing pulse into the line strobes that a video output stage needs. It receives three comparator outputs (low, middle and high thresholds) and a mode bit that picks a two-level or a three-level pulse. From these it recovers the line pulse, the field pulse and the clamp key. The trailing edge of the field pulse arms a short sequence. That sequence starts on the next line pulse and runs one leakage-measurement line, then one cut-off line each for red, green and blue.

The block also drives the blanking enable, a clamp pulse whose leading edge can be held back, an output-clamp strobe for the mode with cut-off control switched off, and a warm-up test strobe. A power-up gate holds the picture blanked. It stays in warm-up until the cut-off comparator answers a test strobe. It then enables cut-off control and unblanks the picture only after a fixed number of further fields. An adaptive-black line window counts lines after each field and spans a length set by the line standard and the rate.

Top module: `meas_line_seq`

## Requirements
- R1: Decoding. In three-level mode (`two_level`=0) the line pulse is `sc_mid`, the clamp key is `sc_high`, and the field pulse is `sc_low` without `sc_mid`. In two-level mode the clamp key is `sc_mid`. Once the field pulse has started it persists through line pulses for as long as `sc_low` stays high.
- R2: The falling edge of the field pulse arms the sequencer. The next rising line pulse starts the leakage line (`leak_line`=1).
- R3: Each following rising line pulse advances the sequence: leakage, then red, then green, then blue, then idle. At most one of `leak_line`, `cut_r`, `cut_g`, `cut_b` is high.
- R4: `blank` is high during the line pulse, the field pulse and all four measurement lines, and at all times until `picture_on` is high. Otherwise it is low.
- R5: `cut_r`/`cut_g`/`cut_b` are high only on their own colour line, and only while cut-off control is enabled.
- R6: With `cutoff_off`=1, `fix_clamp` is high on all four measurement lines and no cut-off strobe is driven.
- R7: After reset, `warm_pulse` is high on the three colour lines and `cutoff_en` is low. The first cycle in which `cut_above` is seen high during `warm_pulse` enables `cutoff_en`, while the picture stays blanked.
- R8: `picture_on` rises on the DELAY_FIELDS-th field falling edge after `cutoff_en` rose, and then stays high. With `cutoff_off`=1 the warm-up is skipped and `picture_on` rises at once.
- R9: `clamp_pulse` follows the clamp key. Its leading edge is delayed by CLAMP_DLY clocks unless `no_clamp_delay`=1.
- R10: A field falling edge in the middle of a sequence restarts it, so the next line pulse is a leakage line again.
- R11: `adbl_win` opens at the field falling edge and closes at the L-th line pulse after it. L is 272 (`ntsc_mode`=0) or 224 (`ntsc_mode`=1), and is doubled when `double_rate`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sc_low | input | 1 | Sandcastle above low threshold |
| sc_mid | input | 1 | Sandcastle above middle threshold |
| sc_high | input | 1 | Sandcastle above high threshold |
| two_level | input | 1 | 1 = two-level sandcastle |
| cutoff_off | input | 1 | 1 = cut-off control off, outputs clamped |
| no_clamp_delay | input | 1 | 1 = clamp leading edge not delayed |
| ntsc_mode | input | 1 | Selects 224-line window base |
| double_rate | input | 1 | Doubles the window length |
| cut_above | input | 1 | Cut-off comparator above threshold |
| blank | output | 1 | Blank video to ultra-black |
| clamp_pulse | output | 1 | Input clamp pulse |
| fix_clamp | output | 1 | Fixed-level output clamp strobe |
| leak_line | output | 1 | Leakage measurement line |
| cut_r | output | 1 | Red cut-off measurement line |
| cut_g | output | 1 | Green cut-off measurement line |
| cut_b | output | 1 | Blue cut-off measurement line |
| warm_pulse | output | 1 | Warm-up test strobe |
| cutoff_en | output | 1 | Cut-off control enabled |
| picture_on | output | 1 | Picture unblanked by power-up gate |
| adbl_win | output | 1 | Adaptive-black line window |

## Verification
The properties assume well-formed sandcastle input. The comparator outputs are nested, so `sc_mid` implies `sc_low`, and each level holds for several clocks. The mode bits change only between frames. The stimulus draws line-pulse widths, line lengths, field lengths and the number of trailing lines from a seeded generator, but every line pulse is at least three clocks wide. The mode bits are changed only while the input sits at black level.

// File: rtl/msq_pkg.sv
package msq_pkg;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_ARMED,
        MS_LEAK,
        MS_RED,
        MS_GRN,
        MS_BLU
    } meas_t;

    typedef enum logic [1:0] {
        PW_WARM,
        PW_CTRL,
        PW_RUN
    } pwr_t;

    typedef struct packed {
        logic line_p;
        logic field_p;
        logic key_p;
        logic line_rise;
        logic field_fall;
    } sc_t;

    function automatic int unsigned window_lines(input int unsigned pal_n,
                                                 input int unsigned ntsc_n,
                                                 input logic is_ntsc,
                                                 input logic dbl);
        int unsigned n;
        n = is_ntsc ? ntsc_n : pal_n;
        return dbl ? 2 * n : n;
    endfunction

endpackage

// File: rtl/msq_decode.sv
module msq_decode
    import msq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sc_low,
    input  logic sc_mid,
    input  logic sc_high,
    input  logic two_level,
    output sc_t  sc
);
    logic s_low, s_mid, s_high;
    logic line_q, field_q;
    logic field_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_low   <= 1'b0;
            s_mid   <= 1'b0;
            s_high  <= 1'b0;
            line_q  <= 1'b0;
            field_q <= 1'b0;
        end else begin
            s_low   <= sc_low;
            s_mid   <= sc_mid;
            s_high  <= sc_high;
            line_q  <= s_mid;
            field_q <= field_now;
        end
    end

    // field level persists across line pulses riding on it
    assign field_now = s_low & (field_q | ~s_mid);

    always_comb begin
        sc.line_p     = s_mid;
        sc.field_p    = field_now;
        sc.key_p      = two_level ? s_mid : s_high;
        sc.line_rise  = s_mid & ~line_q;
        sc.field_fall = field_q & ~field_now;
    end

    // R1: a field pulse never starts while the line level is present
    assert_field_start_R1: assert property (@(posedge clk) disable iff (rst)
        (!field_q && s_mid) |-> !sc.field_p);
endmodule

// File: rtl/msq_seq.sv
module msq_seq
    import msq_pkg::*;
#(
    parameter int unsigned PAL_LINES  = 272,
    parameter int unsigned NTSC_LINES = 224
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  line_rise,
    input  logic  field_fall,
    input  logic  field_p,
    input  logic  ntsc_mode,
    input  logic  double_rate,
    output meas_t st,
    output logic  adbl_win
);
    localparam int unsigned MAXL = 2 * ((PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES);
    localparam int unsigned CW   = $clog2(MAXL + 1);

    logic [CW-1:0] lcount;
    logic [CW-1:0] limit;

    assign limit = CW'(window_lines(PAL_LINES, NTSC_LINES, ntsc_mode, double_rate));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= MS_IDLE;
            lcount <= '1;
        end else begin
            if (field_fall) begin
                st     <= MS_ARMED;
                lcount <= '0;
            end else if (line_rise) begin
                if (lcount < limit) lcount <= lcount + 1'b1;
                unique case (st)
                    MS_ARMED: st <= MS_LEAK;
                    MS_LEAK:  st <= MS_RED;
                    MS_RED:   st <= MS_GRN;
                    MS_GRN:   st <= MS_BLU;
                    MS_BLU:   st <= MS_IDLE;
                    default:  st <= MS_IDLE;
                endcase
            end
        end
    end

    assign adbl_win = ~field_p & (lcount < limit);

    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        field_fall |=> st == MS_ARMED);
    assert_leak_to_red_R3: assert property (@(posedge clk) disable iff (rst)
        (st == MS_LEAK && line_rise && !field_fall) |=> st == MS_RED);
    assert_arm_start_R2: assert property (@(posedge clk) disable iff (rst)
        (st == MS_ARMED && line_rise && !field_fall) |=> st == MS_LEAK);
endmodule

// File: rtl/msq_power.sv
module msq_power
    import msq_pkg::*;
#(
    parameter int unsigned DELAY_FIELDS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic cutoff_off,
    input  logic warm_probe,
    input  logic cut_above,
    input  logic field_fall,
    output pwr_t pw
);
    localparam int unsigned DW = $clog2(DELAY_FIELDS + 1);

    logic [DW-1:0] fcnt;
    logic          cut_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pw    <= PW_WARM;
            fcnt  <= '0;
            cut_q <= 1'b0;
        end else begin
            cut_q <= cut_above;
            if (cutoff_off) begin
                pw <= PW_RUN;
            end else begin
                unique case (pw)
                    PW_WARM: if (warm_probe && cut_q) begin
                        pw   <= PW_CTRL;
                        fcnt <= '0;
                    end
                    PW_CTRL: if (field_fall) begin
                        if (fcnt == DW'(DELAY_FIELDS - 1)) pw <= PW_RUN;
                        else fcnt <= fcnt + 1'b1;
                    end
                    default: pw <= PW_RUN;
                endcase
            end
        end
    end

    assert_run_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        pw == PW_RUN |=> pw == PW_RUN);
    assert_warm_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (pw == PW_WARM && !cutoff_off && !(warm_probe && cut_q)) |=> pw == PW_WARM);
endmodule

// File: rtl/msq_clamp.sv
module msq_clamp #(
    parameter int unsigned CLAMP_DLY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic key_p,
    input  logic no_delay,
    output logic clamp_pulse
);
    localparam int unsigned CDW = $clog2(CLAMP_DLY + 1);

    logic [CDW-1:0] dcnt;

    always_ff @(posedge clk) begin
        if (rst || !key_p) dcnt <= '0;
        else if (dcnt != CDW'(CLAMP_DLY)) dcnt <= dcnt + 1'b1;
    end

    assign clamp_pulse = key_p & (no_delay | (dcnt == CDW'(CLAMP_DLY)));

    assert_clamp_delayed_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(clamp_pulse) && !no_delay) |-> $past(key_p));
endmodule

// File: rtl/meas_line_seq.sv
module meas_line_seq
    import msq_pkg::*;
#(
    parameter int unsigned PAL_LINES    = 272,
    parameter int unsigned NTSC_LINES   = 224,
    parameter int unsigned DELAY_FIELDS = 3,
    parameter int unsigned CLAMP_DLY    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sc_low,
    input  logic sc_mid,
    input  logic sc_high,
    input  logic two_level,
    input  logic cutoff_off,
    input  logic no_clamp_delay,
    input  logic ntsc_mode,
    input  logic double_rate,
    input  logic cut_above,
    output logic blank,
    output logic clamp_pulse,
    output logic fix_clamp,
    output logic leak_line,
    output logic cut_r,
    output logic cut_g,
    output logic cut_b,
    output logic warm_pulse,
    output logic cutoff_en,
    output logic picture_on,
    output logic adbl_win
);
    sc_t   sc;
    meas_t st;
    pwr_t  pw;
    logic  in_meas, in_colour;

    msq_decode u_dec (
        .clk(clk), .rst(rst), .sc_low(sc_low), .sc_mid(sc_mid),
        .sc_high(sc_high), .two_level(two_level), .sc(sc)
    );

    msq_seq #(.PAL_LINES(PAL_LINES), .NTSC_LINES(NTSC_LINES)) u_seq (
        .clk(clk), .rst(rst), .line_rise(sc.line_rise), .field_fall(sc.field_fall),
        .field_p(sc.field_p), .ntsc_mode(ntsc_mode), .double_rate(double_rate),
        .st(st), .adbl_win(adbl_win)
    );

    msq_power #(.DELAY_FIELDS(DELAY_FIELDS)) u_pwr (
        .clk(clk), .rst(rst), .cutoff_off(cutoff_off), .warm_probe(warm_pulse),
        .cut_above(cut_above), .field_fall(sc.field_fall), .pw(pw)
    );

    msq_clamp #(.CLAMP_DLY(CLAMP_DLY)) u_clp (
        .clk(clk), .rst(rst), .key_p(sc.key_p), .no_delay(no_clamp_delay),
        .clamp_pulse(clamp_pulse)
    );

    always_comb begin
        in_colour  = (st == MS_RED) | (st == MS_GRN) | (st == MS_BLU);
        in_meas    = in_colour | (st == MS_LEAK);
        leak_line  = (st == MS_LEAK);
        cutoff_en  = (pw != PW_WARM) & ~cutoff_off;
        picture_on = (pw == PW_RUN);
        warm_pulse = (pw == PW_WARM) & ~cutoff_off & in_colour;
        cut_r      = (st == MS_RED) & cutoff_en;
        cut_g      = (st == MS_GRN) & cutoff_en;
        cut_b      = (st == MS_BLU) & cutoff_en;
        fix_clamp  = cutoff_off & in_meas;
        blank      = sc.line_p | sc.field_p | in_meas | ~picture_on;
    end

    assert_one_line_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({leak_line, cut_r, cut_g, cut_b}));
    assert_blank_meas_R4: assert property (@(posedge clk) disable iff (rst)
        (leak_line || cut_r || cut_g || cut_b || fix_clamp) |-> blank);
    assert_warm_no_ctrl_R7: assert property (@(posedge clk) disable iff (rst)
        warm_pulse |-> !cutoff_en && !picture_on);
    assert_fix_no_cut_R6: assert property (@(posedge clk) disable iff (rst)
        fix_clamp |-> !(cut_r || cut_g || cut_b || warm_pulse));
endmodule

// File: tb/meas_line_seq_test.sv
module meas_line_seq_test;
    localparam int DLY = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sc_low = 0, sc_mid = 0, sc_high = 0, two_level = 0, cutoff_off = 0;
    logic no_clamp_delay = 0, ntsc_mode = 0, double_rate = 0, cut_above = 0;
    logic blank, clamp_pulse, fix_clamp, leak_line, cut_r, cut_g, cut_b;
    logic warm_pulse, cutoff_en, picture_on, adbl_win;

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [3:0] s_meas;
    logic s_warm, s_fix, s_blank, s_adbl;

    always #2 clk = ~clk;

    meas_line_seq #(.DELAY_FIELDS(3), .CLAMP_DLY(DLY)) uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_line(input int pw, input int body);
        sc_low = 1; sc_mid = 1;
        tick(pw);
        sc_low = 0; sc_mid = 0;
        tick(4);
        s_meas = {leak_line, cut_r, cut_g, cut_b};
        s_warm = warm_pulse; s_fix = fix_clamp; s_blank = blank; s_adbl = adbl_win;
        tick(body - 4);
    endtask

    task automatic do_field(input int half);
        sc_low = 1; sc_mid = 0;
        tick(half);
        sc_mid = 1; tick(3); sc_mid = 0;
        tick(half);
        chk(blank === 1'b1, "R1 field persists over line pulse", blank, 1);
        sc_low = 0;
        tick(3);
    endtask

    function automatic logic [3:0] exp_seq(input int k);
        return (k >= 1 && k <= 4) ? (4'b1000 >> (k - 1)) : 4'b0000;
    endfunction

    // mode 0 warm-up, 1 cut-off control active, 2 outputs clamped
    task automatic frame(input int mode, input bit pic, input int cut_line, input int nlines);
        logic [3:0] e;
        do_field($urandom_range(12, 6));
        for (int k = 1; k <= nlines; k++) begin
            if (k == cut_line) cut_above = 1;
            do_line($urandom_range(6, 3), $urandom_range(20, 8));
            cut_above = 0;
            if (k != cut_line) begin
                e = exp_seq(k);
                chk(s_meas[3] === e[3], (k == 1) ? "R2 leak line" : "R3 leak line", s_meas[3], e[3]);
                chk(s_meas[2:0] === ((mode == 1) ? e[2:0] : 3'b000), "R5 cut strobes",
                    s_meas[2:0], (mode == 1) ? e[2:0] : 0);
                chk(s_warm === ((mode == 0) && (|e[2:0])), "R7 warm pulse", s_warm,
                    (mode == 0) && (|e[2:0]));
                chk(s_fix === ((mode == 2) && (|e)), "R6 fix clamp", s_fix, (mode == 2) && (|e));
                chk(s_blank === ((|e) || !pic), "R4 blank", s_blank, (|e) || !pic);
            end
        end
    endtask

    task automatic clamp_count(input bit twol, input bit hi, input bit nodly, input int h,
                               input int exp, input string req);
        int cnt = 0;
        two_level = twol; no_clamp_delay = nodly;
        tick(2);
        sc_low = 1; sc_mid = 1; sc_high = hi;
        for (int i = 1; i <= h + 3; i++) begin
            @(negedge clk);
            if (clamp_pulse) cnt++;
            if (i == h) begin sc_low = 0; sc_mid = 0; sc_high = 0; end
        end
        chk(cnt == exp, req, cnt, exp);
        two_level = 0; no_clamp_delay = 0;
        tick(4);
    endtask

    task automatic window_check(input bit nt, input bit hd, input int lim, input string req);
        ntsc_mode = nt; double_rate = hd;
        do_field(6);
        for (int k = 1; k <= lim; k++) begin
            do_line(3, 9);
            if (k == lim - 1) chk(s_adbl === 1'b1, req, s_adbl, 1);
            if (k == lim)     chk(s_adbl === 1'b0, req, s_adbl, 0);
        end
        ntsc_mode = 0; double_rate = 0;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        tick(4);
        rst = 0;
        tick(1);
        chk(picture_on === 1'b0, "R8 reset picture off", picture_on, 0);
        chk(cutoff_en === 1'b0, "R7 reset cut-off off", cutoff_en, 0);
        chk(blank === 1'b1, "R4 reset blank", blank, 1);
        chk({leak_line, cut_r, cut_g, cut_b} === 4'b0, "R3 reset idle", leak_line, 0);

        frame(0, 0, 0, 6);
        chk(cutoff_en === 1'b0, "R7 no comparator stays warm", cutoff_en, 0);
        frame(0, 0, 4, 6);
        chk(cutoff_en === 1'b1, "R7 comparator enables cut-off", cutoff_en, 1);
        chk(picture_on === 1'b0, "R7 still blanked", picture_on, 0);
        frame(1, 0, 0, 5);
        frame(1, 0, 0, 5);
        chk(picture_on === 1'b0, "R8 second field still blanked", picture_on, 0);
        frame(1, 1, 0, 6);
        chk(picture_on === 1'b1, "R8 unblank after delay", picture_on, 1);

        for (int f = 0; f < 6; f++) frame(1, 1, 0, 5 + $urandom_range(3, 0));

        // R10 restart mid-sequence
        do_field(8);
        do_line(4, 12);
        do_line(4, 12);
        chk(s_meas === 4'b0100, "R10 red before restart", s_meas, 4'b0100);
        do_field(8);
        do_line(4, 12);
        chk(s_meas === 4'b1000, "R10 restart with leak", s_meas, 4'b1000);
        do_line(4, 12);
        chk(s_meas === 4'b0100, "R10 then red", s_meas, 4'b0100);

        clamp_count(0, 1, 0, 10, 10 - DLY, "R9 delayed clamp");
        clamp_count(0, 1, 1, 10, 10, "R9 undelayed clamp");
        clamp_count(1, 0, 1, 8, 8, "R1 two-level key on mid");
        clamp_count(0, 0, 1, 8, 0, "R1 three-level no key on mid");

        window_check(0, 0, 272, "R11 PAL window");
        window_check(1, 1, 448, "R11 NTSC double window");

        cutoff_off = 1;
        tick(2);
        frame(2, 1, 0, 6);
        chk(picture_on === 1'b1, "R8 picture stays on", picture_on, 1);

        rst = 1; tick(3); rst = 0;
        tick(2);
        chk(picture_on === 1'b1, "R8 clamped mode skips warm-up", picture_on, 1);
        frame(2, 1, 0, 5);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule